// File: doc/BRIEF.md
# Iterative Integer Divider with Status Flag Update

This execution unit performs 32-bit integer division for a processor pipeline. A single-cycle `start` pulse presents a dividend, a divisor, a two-bit operation code and a short-form marker. The unit then returns a quotient, a remainder, a write strobe for each of the two destination registers, and new values for the zero, sign and overflow status flags. Each flag has its own update strobe. Every result appears for exactly one cycle, marked by `done`.

Ordinary divisions pass through a radix-2 restoring divider that works on magnitudes, one quotient bit per clock. Signs are restored at the output. Two operand patterns skip the iteration and finish at once. A zero divisor only raises overflow and writes nothing else. The signed most-negative-by-minus-one case writes fixed results with a fixed flag pattern instead of wrapping. Operation code encoding: `00` signed word, `01` unsigned word, `10` signed halfword divisor, `11` unsigned halfword divisor.

Top module: `intdiv_unit`

## Requirements
- R1: When the effective divisor is zero, the result cycle sets `flag_ov`=1 with `flag_ov_we`=1, and `quo_we`, `rem_we`, `flag_z_we` and `flag_s_we` are all 0. In the halfword forms the divisor counts as zero when its low 16 bits are zero.
- R2: For op `00` or `10`, a dividend of 0x80000000 with an effective divisor of 0xFFFFFFFF gives quotient 0x80000000 and remainder 0. It sets `flag_ov`=1 and `flag_s`=1, clears `flag_z`, and raises all three flag strobes.
- R3: For any result that is neither R1 nor R2, all three flag strobes are 1, `flag_z`=1 exactly when the quotient is 0, `flag_s` equals quotient bit 31, and `flag_ov`=0.
- R4: Signed word division (op `00`) truncates toward zero. A nonzero remainder takes the sign of the dividend, and dividend = quotient*divisor + remainder.
- R5: Unsigned word division (op `01`) treats both operands as unsigned 32-bit values. Divide-by-zero is its only special case.
- R6: Op `10` sign-extends divisor bits 15:0 to 32 bits and ignores divisor bits 31:16. The dividend is always used as a full 32-bit signed value.
- R7: Op `11` zero-extends divisor bits 15:0 and ignores divisor bits 31:16. The dividend is used as a full 32-bit unsigned value.
- R8: When `short_form`=1 with op `10`, `rem_we` stays 0 while `quo_we` is raised. For the other ops, `short_form` has no effect, and every non-R1 result raises both `quo_we` and `rem_we`.
- R9: Take a start accepted at clock edge k. An R1 or R2 case shows `done` in the cycle right after edge k. Any other case shows `done` in the cycle right after edge k+32.
- R10: `done` is high for exactly one cycle per accepted start. Outside that cycle, all strobes, `quotient`, `remainder` and the flag values are 0.
- R11: `busy` is high from the accepted start edge through the `done` cycle. A `start` pulse seen while `busy` is high, including during the `done` cycle, is ignored.
- R12: After a synchronous reset, `busy` and `done` are 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only when idle |
| op | input | 2 | Operation code (00 sword, 01 uword, 10 shalf, 11 uhalf) |
| short_form | input | 1 | Quotient-only variant of op 10 |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand (low 16 bits in halfword forms) |
| busy | output | 1 | Operation in progress or result cycle |
| done | output | 1 | Result cycle marker |
| quotient | output | 32 | Quotient value |
| remainder | output | 32 | Remainder value |
| quo_we | output | 1 | Quotient register write strobe |
| rem_we | output | 1 | Remainder register write strobe |
| flag_z | output | 1 | New zero flag |
| flag_s | output | 1 | New sign flag |
| flag_ov | output | 1 | New overflow flag |
| flag_z_we | output | 1 | Zero flag update strobe |
| flag_s_we | output | 1 | Sign flag update strobe |
| flag_ov_we | output | 1 | Overflow flag update strobe |

## Verification
The assertions watch every cycle for the following. Strobes only appear together with `done`, and `done` never lasts two cycles. The divide-by-zero strobe pattern is quiet, and the overflow pattern forces its fixed values. Zero and sign agree with the quotient on ordinary results. The iteration counter advances undisturbed by `start`, and the partial remainder stays below the divisor. The arithmetic itself needs the bench's scenarios, which compare against a behavioural model on every clock: signed truncation, halfword extension of the divisor, the suppressed remainder strobe of the short form, the two latencies, and starts dropped while busy.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = 16;
    localparam int EXT_W  = DATA_W - HALF_W;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        OP_SWORD = 2'b00,
        OP_UWORD = 2'b01,
        OP_SHALF = 2'b10,
        OP_UHALF = 2'b11
    } div_op_e;

    typedef enum logic [1:0] {
        CASE_NORMAL  = 2'b00,
        CASE_DIVZERO = 2'b01,
        CASE_SOVF    = 2'b10
    } div_case_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_DONE = 2'b10
    } div_state_e;

    typedef struct packed {
        div_case_e           kind;
        logic                neg_q;
        logic                neg_r;
        logic                no_rem;
        logic [DATA_W-1:0]   mag_n;
        logic [DATA_W-1:0]   mag_d;
    } div_prep_t;

    typedef struct packed {
        logic [DATA_W-1:0] quo;
        logic [DATA_W-1:0] rem;
        logic              quo_we;
        logic              rem_we;
        logic              z;
        logic              s;
        logic              ov;
        logic              z_we;
        logic              s_we;
        logic              ov_we;
    } div_result_t;

    // Effective divisor: full word, or low half sign/zero extended
    function automatic logic [DATA_W-1:0] eff_divisor(input div_op_e op,
                                                      input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] e;
        case (op)
            OP_SHALF: e = {{EXT_W{d[HALF_W-1]}}, d[HALF_W-1:0]};
            OP_UHALF: e = {{EXT_W{1'b0}}, d[HALF_W-1:0]};
            default:  e = d;
        endcase
        return e;
    endfunction

    function automatic logic [DATA_W-1:0] magnitude(input logic neg,
                                                    input logic [DATA_W-1:0] v);
        return neg ? (~v + 1'b1) : v;
    endfunction

endpackage

// File: rtl/intdiv_prep.sv
module intdiv_prep
    import intdiv_pkg::*;
(
    input  div_op_e           op,
    input  logic              short_form,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output div_prep_t         prep
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic              is_signed;
    logic [DATA_W-1:0] eff_d;
    logic              n_neg;
    logic              d_neg;

    always_comb begin
        is_signed   = ~op[0];
        eff_d       = eff_divisor(op, divisor);
        n_neg       = is_signed & dividend[DATA_W-1];
        d_neg       = is_signed & eff_d[DATA_W-1];

        prep.mag_n  = magnitude(n_neg, dividend);
        prep.mag_d  = magnitude(d_neg, eff_d);
        prep.neg_q  = n_neg ^ d_neg;
        prep.neg_r  = n_neg;
        prep.no_rem = short_form && (op == OP_SHALF);

        if (eff_d == '0)
            prep.kind = CASE_DIVZERO;
        else if (is_signed && dividend == MOST_NEG && eff_d == '1)
            prep.kind = CASE_SOVF;
        else
            prep.kind = CASE_NORMAL;
    end

endmodule

// File: rtl/intdiv_core.sv
module intdiv_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] num,
    input  logic [WIDTH-1:0] den,
    output logic [WIDTH-1:0] quo,
    output logic [WIDTH-1:0] rem
);
    logic [WIDTH-1:0] acc;
    logic [WIDTH-1:0] q_sh;
    logic [WIDTH-1:0] den_r;
    logic [WIDTH:0]   trial;
    logic [WIDTH:0]   diff;
    logic             fits;

    always_comb begin
        trial = {acc, q_sh[WIDTH-1]};
        diff  = trial - {1'b0, den_r};
        fits  = ~diff[WIDTH];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            q_sh  <= '0;
            den_r <= '0;
        end else if (load) begin
            acc   <= '0;
            q_sh  <= num;
            den_r <= den;
        end else if (step) begin
            acc   <= fits ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
            q_sh  <= {q_sh[WIDTH-2:0], fits};
        end
    end

    assign quo = q_sh;
    assign rem = acc;

    // R4
    rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (step && den_r != '0) |=> (acc < den_r));

endmodule

// File: rtl/intdiv_result.sv
module intdiv_result
    import intdiv_pkg::*;
(
    input  logic              valid,
    input  div_case_e         kind,
    input  logic              neg_q,
    input  logic              neg_r,
    input  logic              no_rem,
    input  logic [DATA_W-1:0] q_mag,
    input  logic [DATA_W-1:0] r_mag,
    output div_result_t       res
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] q_signed;
    logic [DATA_W-1:0] r_signed;

    always_comb begin
        q_signed = magnitude(neg_q, q_mag);
        r_signed = magnitude(neg_r, r_mag);
        res      = '0;
        if (valid) begin
            case (kind)
                CASE_DIVZERO: begin
                    res.ov    = 1'b1;
                    res.ov_we = 1'b1;
                end
                CASE_SOVF: begin
                    res.quo    = MOST_NEG;
                    res.rem    = '0;
                    res.quo_we = 1'b1;
                    res.rem_we = ~no_rem;
                    res.z      = 1'b0;
                    res.s      = 1'b1;
                    res.ov     = 1'b1;
                    res.z_we   = 1'b1;
                    res.s_we   = 1'b1;
                    res.ov_we  = 1'b1;
                end
                default: begin
                    res.quo    = q_signed;
                    res.rem    = r_signed;
                    res.quo_we = 1'b1;
                    res.rem_we = ~no_rem;
                    res.z      = (q_signed == '0);
                    res.s      = q_signed[DATA_W-1];
                    res.ov     = 1'b0;
                    res.z_we   = 1'b1;
                    res.s_we   = 1'b1;
                    res.ov_we  = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/intdiv_unit.sv
module intdiv_unit
    import intdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              short_form,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] quotient,
    output logic [DATA_W-1:0] remainder,
    output logic              quo_we,
    output logic              rem_we,
    output logic              flag_z,
    output logic              flag_s,
    output logic              flag_ov,
    output logic              flag_z_we,
    output logic              flag_s_we,
    output logic              flag_ov_we
);
    localparam logic [CNT_W-1:0]  LAST_STEP = CNT_W'(DATA_W - 1);
    localparam logic [DATA_W-1:0] MOST_NEG  = {1'b1, {(DATA_W-1){1'b0}}};

    div_state_e        state;
    logic [CNT_W-1:0]  cnt;
    div_prep_t         prep;
    div_case_e         kind_r;
    logic              neg_q_r;
    logic              neg_r_r;
    logic              no_rem_r;
    logic              accept;
    logic [DATA_W-1:0] core_q;
    logic [DATA_W-1:0] core_r;
    div_result_t       res;

    assign accept = start && (state == ST_IDLE);

    intdiv_prep u_prep (
        .op         (div_op_e'(op)),
        .short_form (short_form),
        .dividend   (dividend),
        .divisor    (divisor),
        .prep       (prep)
    );

    intdiv_core #(.WIDTH(DATA_W)) u_core (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .step (state == ST_RUN),
        .num  (prep.mag_n),
        .den  (prep.mag_d),
        .quo  (core_q),
        .rem  (core_r)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            kind_r   <= CASE_NORMAL;
            neg_q_r  <= 1'b0;
            neg_r_r  <= 1'b0;
            no_rem_r <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        kind_r   <= prep.kind;
                        neg_q_r  <= prep.neg_q;
                        neg_r_r  <= prep.neg_r;
                        no_rem_r <= prep.no_rem;
                        cnt      <= '0;
                        state    <= (prep.kind == CASE_NORMAL) ? ST_RUN : ST_DONE;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_STEP)
                        state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    intdiv_result u_result (
        .valid  (state == ST_DONE),
        .kind   (kind_r),
        .neg_q  (neg_q_r),
        .neg_r  (neg_r_r),
        .no_rem (no_rem_r),
        .q_mag  (core_q),
        .r_mag  (core_r),
        .res    (res)
    );

    assign busy       = (state != ST_IDLE);
    assign done       = (state == ST_DONE);
    assign quotient   = res.quo;
    assign remainder  = res.rem;
    assign quo_we     = res.quo_we;
    assign rem_we     = res.rem_we;
    assign flag_z     = res.z;
    assign flag_s     = res.s;
    assign flag_ov    = res.ov;
    assign flag_z_we  = res.z_we;
    assign flag_s_we  = res.s_we;
    assign flag_ov_we = res.ov_we;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    strobe_in_done_chk: assert property (@(posedge clk) disable iff (rst)
        (quo_we || rem_we || flag_z_we || flag_s_we || flag_ov_we) |-> done);

    // R1
    divzero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (done && flag_ov_we && !flag_s_we) |-> (flag_ov && !quo_we && !rem_we && !flag_z_we));

    // R2
    sovf_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        (done && flag_ov && flag_s_we) |-> (quotient == MOST_NEG && remainder == '0
                                            && flag_s && !flag_z && quo_we));

    // R3
    normal_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (done && quo_we && !flag_ov) |-> (flag_z_we && flag_s_we && flag_ov_we
            && flag_z == (quotient == '0) && flag_s == quotient[DATA_W-1]));

    // R11
    run_undisturbed_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && cnt != LAST_STEP) |=> (state == ST_RUN && cnt == $past(cnt) + 1'b1));

    // R9
    run_length_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |=> (state == ST_DONE) == ($past(cnt) == LAST_STEP));

endmodule

// File: tb/intdiv_unit_tb.sv
module intdiv_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  op;
    logic        short_form;
    logic [31:0] dividend;
    logic [31:0] divisor;
    logic        busy, done;
    logic [31:0] quotient, remainder;
    logic        quo_we, rem_we;
    logic        flag_z, flag_s, flag_ov;
    logic        flag_z_we, flag_s_we, flag_ov_we;

    int checks   = 0;
    int failures = 0;

    // reference model state
    int          m_left = -1;
    string       m_tag  = "R4";
    logic [31:0] e_quo, e_rem;
    logic        e_quo_we, e_rem_we, e_z, e_s, e_ov, e_z_we, e_s_we, e_ov_we;

    always #(CLK_PERIOD/2) clk = ~clk;

    intdiv_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .short_form(short_form),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder), .quo_we(quo_we), .rem_we(rem_we),
        .flag_z(flag_z), .flag_s(flag_s), .flag_ov(flag_ov),
        .flag_z_we(flag_z_we), .flag_s_we(flag_s_we), .flag_ov_we(flag_ov_we)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural expectation from the requirements
    task automatic predict(input logic [1:0] o, input logic sf,
                           input logic [31:0] a, input logic [31:0] b);
        logic [31:0] ed;
        longint      qa, ra, na, da;
        logic [31:0] q;
        case (o)
            2'b10:   ed = {{16{b[15]}}, b[15:0]};
            2'b11:   ed = {16'h0, b[15:0]};
            default: ed = b;
        endcase
        case (o)
            2'b00: m_tag = "R4";
            2'b01: m_tag = "R5";
            2'b10: m_tag = "R6";
            default: m_tag = "R7";
        endcase
        {e_quo, e_rem, e_quo_we, e_rem_we, e_z, e_s, e_ov, e_z_we, e_s_we, e_ov_we} = '0;
        if (ed == 32'h0) begin
            m_tag = "R1"; e_ov = 1; e_ov_we = 1; m_left = 0;
        end else if (!o[0] && a == 32'h8000_0000 && ed == 32'hFFFF_FFFF) begin
            m_tag = "R2"; e_quo = 32'h8000_0000; e_rem = 0;
            e_quo_we = 1; e_rem_we = !(sf && o == 2'b10);
            e_s = 1; e_ov = 1; e_z_we = 1; e_s_we = 1; e_ov_we = 1; m_left = 0;
        end else begin
            if (o[0]) begin
                na = longint'({32'h0, a}); da = longint'({32'h0, ed});
            end else begin
                na = longint'($signed(a)); da = longint'($signed(ed));
            end
            qa = na / da; ra = na % da;
            q = qa[31:0];
            e_quo = q; e_rem = ra[31:0];
            e_quo_we = 1; e_rem_we = !(sf && o == 2'b10);
            e_z = (q == 0); e_s = q[31]; e_ov = 0;
            e_z_we = 1; e_s_we = 1; e_ov_we = 1; m_left = 32;
        end
    endtask

    always @(posedge clk) begin
        if (rst) m_left = -1;
        else if (m_left > 0) m_left = m_left - 1;
        else if (m_left == 0) m_left = -1;
        else if (start) predict(op, short_form, dividend, divisor);
    end

    // compare with the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R9", "done", done, m_left == 0);
            chk("R11", "busy", busy, m_left >= 0);
            if (m_left == 0) begin
                chk(m_tag, "quotient", quotient, e_quo);
                chk(m_tag, "remainder", remainder, e_rem);
                chk("R1", "quo_we", quo_we, e_quo_we);
                chk("R8", "rem_we", rem_we, e_rem_we);
                chk("R3", "flags", {flag_z, flag_s, flag_ov}, {e_z, e_s, e_ov});
                chk("R3", "flag strobes", {flag_z_we, flag_s_we, flag_ov_we}, {e_z_we, e_s_we, e_ov_we});
            end else begin
                chk("R10", "idle outputs",
                    {quo_we, rem_we, flag_z, flag_s, flag_ov, flag_z_we, flag_s_we, flag_ov_we},
                    32'h0);
                chk("R10", "idle data", quotient | remainder, 32'h0);
            end
        end
    end

    task automatic issue(input logic [1:0] o, input logic sf,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        while (busy) @(negedge clk);
        op = o; short_form = sf; dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int unsigned seed;
        rst = 1'b1; start = 1'b0; op = 2'b00; short_form = 1'b0;
        dividend = '0; divisor = '0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "busy/done", {busy, done}, 32'h0);
        chk("R12", "outputs", quotient | remainder | {quo_we, rem_we, flag_ov_we}, 32'h0);
        rst = 1'b0;

        // R4 signed truncation, every sign combination
        issue(2'b00, 0, 32'd100, 32'd7);
        issue(2'b00, 0, -32'sd100, 32'd7);
        issue(2'b00, 0, 32'd100, -32'sd7);
        issue(2'b00, 0, -32'sd100, -32'sd7);
        issue(2'b00, 0, 32'd0, 32'd5);
        issue(2'b00, 0, 32'h8000_0000, 32'd1);
        // R1 divide by zero in each form
        issue(2'b00, 0, 32'd55, 32'd0);
        issue(2'b01, 0, 32'd55, 32'd0);
        issue(2'b10, 0, 32'd55, 32'hABCD_0000);
        issue(2'b11, 0, 32'd55, 32'h1234_0000);
        // R2 signed overflow, word and halfword
        issue(2'b00, 0, 32'h8000_0000, 32'hFFFF_FFFF);
        issue(2'b10, 0, 32'h8000_0000, 32'h1234_FFFF);
        issue(2'b10, 1, 32'h8000_0000, 32'h0000_FFFF);
        // R5 unsigned word, no overflow special
        issue(2'b01, 0, 32'hFFFF_FFFF, 32'd1);
        issue(2'b01, 0, 32'h8000_0000, 32'hFFFF_FFFF);
        issue(2'b01, 0, 32'hFFFF_FFFF, 32'd10);
        // R6 signed halfword divisor extension
        issue(2'b10, 0, 32'd100000, 32'hFFFF_8000);
        issue(2'b10, 0, -32'sd1000, 32'h7777_0007);
        // R7 unsigned halfword divisor extension
        issue(2'b11, 0, 32'hFFFF_FFFF, 32'hABCD_8000);
        issue(2'b11, 0, 32'd12345, 32'hFFFF_0003);
        // R8 short form: remainder strobe dropped only for op 10
        issue(2'b10, 1, -32'sd77, 32'h0000_0005);
        issue(2'b00, 1, -32'sd77, 32'd5);
        issue(2'b11, 1, 32'd77, 32'd5);

        // R11 start during run is ignored
        @(negedge clk);
        op = 2'b00; short_form = 0; dividend = 32'd999; divisor = 32'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        op = 2'b01; dividend = 32'd1; divisor = 32'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        // R11 start in the done cycle is ignored as well
        op = 2'b00; dividend = 32'd4; divisor = 32'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11", "busy after done", busy, 1'b0);
        repeat (3) @(negedge clk);

        // mixed operands from a fixed generator
        seed = 32'h1357_9BDF;
        for (int i = 0; i < 24; i++) begin
            logic [31:0] a, b;
            seed = seed * 32'd1103515245 + 32'd12345;
            a = seed;
            seed = seed * 32'd1103515245 + 32'd12345;
            b = (i % 3 == 0) ? (seed >> (seed[4:0])) : seed;
            issue(seed[1:0], seed[2], a, b);
        end

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule